// File: doc/BRIEF.md
# Processor Idle-State Clock Sequencer

This block moves a processor between the running state (C0) and two idle depths, C2 and C3. It drives four active-low clock-control pins in a fixed order. A halt pin stops the instruction stream. A sleep pin puts the core into its sleep mode. A clock-stop pin removes the processor clock. A deep-idle status pin warns a graphics device that C3 residency is in progress.

Entry begins when the processor reads one of two dedicated level addresses over a simple read strobe. One address selects C2 and the other selects C3. Each pin change is held for a parameterised minimum number of cycles before the next one.

Exit is triggered by a qualified wake event. Which events qualify depends on the depth: a bus-master request wakes the processor only from C3. On exit, the entry steps are undone in reverse order. After the clock-stop pin is released, a programmable settle time is added to that step.

Top module: `cpu_idle_seq`

## Requirements
- R1: After reset all four pins (`deep_idle_n`, `stop_clk_n`, `cpu_sleep_n`, `cpu_clk_stop_n`) are high (inactive) and the block is in C0.
- R2: With `rd_en` high and `rd_addr` equal to `LVL2_ADDR` while in C0, `stop_clk_n` goes low at that clock edge. During C2 residency it is the only asserted pin.
- R3: With `rd_en` high and `rd_addr` equal to `LVL3_ADDR` while in C0, `deep_idle_n` goes low at that edge. `stop_clk_n` follows STEP_MIN cycles later, `cpu_sleep_n` after 2*STEP_MIN cycles, and `cpu_clk_stop_n` after 3*STEP_MIN cycles.
- R4: `cpu_clk_stop_n` is low only while both `cpu_sleep_n` and `deep_idle_n` are low. `cpu_sleep_n` is low only while `stop_clk_n` is low.
- R5: An interrupt line that is high with its mask bit at 0 is a wake event from both C2 and C3. An interrupt line whose mask bit is 1 has no effect.
- R6: A high level on `nmi_evt`, `smi_evt`, `init_evt` or `kbc_reset_req` is a wake event from both C2 and C3.
- R7: `bm_req` is a wake event from C3. It has no effect in C2.
- R8: On a wake event in C3 residency, `cpu_clk_stop_n` rises at the next edge. `cpu_sleep_n` rises STEP_MIN+`settle_cycles` cycles after that. `stop_clk_n` rises STEP_MIN cycles later, and `deep_idle_n` rises STEP_MIN cycles after that, returning the block to C0.
- R9: On a wake event in C2 residency, `stop_clk_n` rises at the next edge and the block is back in C0.
- R10: A wake event that arrives during entry is acted on at the end of the current step. At that point the most recently asserted pin is released, and the remaining pins are released STEP_MIN cycles apart.
- R11: Reads of either level address outside C0 are ignored, and reads of any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Read address |
| settle_cycles | input | SETTLE_W | Extra cycles after clock restart before sleep release |
| irq_req | input | NUM_IRQ | Interrupt request lines, active high |
| irq_mask | input | NUM_IRQ | Per-line mask, 1 = masked |
| nmi_evt | input | 1 | Internal event raising NMI |
| smi_evt | input | 1 | Internal event raising SMI |
| init_evt | input | 1 | Internal event raising INIT |
| kbc_reset_req | input | 1 | Keyboard-controller reset request |
| bm_req | input | 1 | Bus-master request (internal, external or DMA) |
| deep_idle_n | output | 1 | C3 status for the graphics device, active low |
| stop_clk_n | output | 1 | Halt instruction stream, active low |
| cpu_sleep_n | output | 1 | Processor sleep, active low |
| cpu_clk_stop_n | output | 1 | Processor clock stop, active low |

## Verification
Every pin is a direct decode of registered state, so a read or wake event sampled at edge E shows on the pins right after E. Later steps land at fixed multiples of STEP_MIN, plus `settle_cycles` for the sleep release.

The bench drives inputs on falling edges and counts falling edges from the one that follows the stimulus edge. It samples each pin just before and just after every expected transition. This shows both that a change is not early and that it is not late.

For events that must be ignored, and for a wake event held during an entry step, the pins are sampled for several cycles afterwards.

// File: rtl/cpu_idle_pkg.sv
package cpu_idle_pkg;

    typedef enum logic [1:0] {
        PH_RUN,
        PH_ENTER,
        PH_RESIDE,
        PH_EXIT
    } phase_e;

    typedef enum logic {
        DEPTH_C2,
        DEPTH_C3
    } depth_e;

    localparam int STAGE_W  = 3;
    localparam int NUM_PINS = 4;

    // Pin index in the decode vector; the C3 entry order follows the index.
    localparam int PIN_DEEP    = 0;
    localparam int PIN_STOPCLK = 1;
    localparam int PIN_SLEEP   = 2;
    localparam int PIN_CPUCLK  = 3;

    localparam logic [STAGE_W-1:0] TOP_C2 = STAGE_W'(1);
    localparam logic [STAGE_W-1:0] TOP_C3 = STAGE_W'(NUM_PINS);

    typedef struct packed {
        phase_e               phase;
        depth_e               depth;
        logic [STAGE_W-1:0]   stage;
    } seq_state_t;

    // Stage at or above which a pin is asserted; zero means never.
    function automatic logic [STAGE_W-1:0] pin_threshold(depth_e d, int idx);
        logic [STAGE_W-1:0] thr;
        if (d == DEPTH_C3) begin
            thr = STAGE_W'(idx + 1);
        end else if (idx == PIN_STOPCLK) begin
            thr = STAGE_W'(1);
        end else begin
            thr = '0;
        end
        return thr;
    endfunction

endpackage

// File: rtl/cpu_idle_brk_qual.sv
module cpu_idle_brk_qual #(
    parameter int NUM_IRQ = 24
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               nmi_evt,
    input  logic               smi_evt,
    input  logic               init_evt,
    input  logic               kbc_reset_req,
    input  logic               bm_req,
    input  logic               in_c3,
    output logic               wake
);

    logic irq_wake;
    logic sys_wake;
    logic bus_wake;

    always_comb begin
        irq_wake = |(irq_req & ~irq_mask);
        sys_wake = nmi_evt | smi_evt | init_evt | kbc_reset_req;
        // bus masters need snoops, which only a stopped clock blocks
        bus_wake = bm_req & in_c3;
        wake     = irq_wake | sys_wake | bus_wake;
    end

endmodule

// File: rtl/cpu_idle_step_timer.sv
module cpu_idle_step_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);

    logic [TMR_W-1:0] cnt_d;
    logic [TMR_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cpu_idle_pin_map.sv
module cpu_idle_pin_map
    import cpu_idle_pkg::*;
(
    input  depth_e                depth,
    input  logic [STAGE_W-1:0]    stage,
    output logic [NUM_PINS-1:0]   pin_on
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic [STAGE_W-1:0] thr;
        always_comb begin
            thr       = pin_threshold(depth, g);
            pin_on[g] = (thr != '0) && (stage >= thr);
        end
    end

endmodule

// File: rtl/cpu_idle_seq_ctrl.sv
module cpu_idle_seq_ctrl
    import cpu_idle_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] LVL2_ADDR = 8'h14,
    parameter logic [ADDR_W-1:0] LVL3_ADDR = 8'h15,
    parameter int                STEP_MIN  = 4,
    parameter int                SETTLE_W  = 8,
    parameter int                TMR_W     = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                wake,
    input  logic                tmr_expired,
    output logic                tmr_load,
    output logic [TMR_W-1:0]    tmr_val,
    output depth_e              depth,
    output logic [STAGE_W-1:0]  stage
);

    localparam logic [TMR_W-1:0] BASE_HOLD = TMR_W'(STEP_MIN - 1);

    seq_state_t cur_q;
    seq_state_t nxt_d;

    logic               hit_l2;
    logic               hit_l3;
    logic               unwind;
    logic [STAGE_W-1:0] top_stage;

    always_comb begin
        nxt_d     = cur_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unwind    = 1'b0;
        hit_l2    = rd_en && (rd_addr == LVL2_ADDR);
        hit_l3    = rd_en && (rd_addr == LVL3_ADDR);
        top_stage = (cur_q.depth == DEPTH_C3) ? TOP_C3 : TOP_C2;

        case (cur_q.phase)
            PH_RUN: begin
                if (hit_l3 || hit_l2) begin
                    nxt_d.phase = PH_ENTER;
                    nxt_d.depth = hit_l3 ? DEPTH_C3 : DEPTH_C2;
                    nxt_d.stage = STAGE_W'(1);
                    tmr_load    = 1'b1;
                    tmr_val     = BASE_HOLD;
                end
            end
            PH_ENTER: begin
                if (tmr_expired) begin
                    if (wake) begin
                        unwind = 1'b1;
                    end else if (cur_q.stage == top_stage) begin
                        nxt_d.phase = PH_RESIDE;
                    end else begin
                        nxt_d.stage = cur_q.stage + STAGE_W'(1);
                        tmr_load    = 1'b1;
                        tmr_val     = BASE_HOLD;
                    end
                end
            end
            PH_RESIDE: begin
                if (wake) begin
                    unwind = 1'b1;
                end
            end
            PH_EXIT: begin
                if (tmr_expired) begin
                    unwind = 1'b1;
                end
            end
            default: begin
                nxt_d.phase = PH_RUN;
                nxt_d.stage = '0;
            end
        endcase

        if (unwind) begin
            nxt_d.stage = cur_q.stage - STAGE_W'(1);
            if (nxt_d.stage == '0) begin
                nxt_d.phase = PH_RUN;
            end else begin
                nxt_d.phase = PH_EXIT;
                tmr_load    = 1'b1;
                if ((cur_q.depth == DEPTH_C3) && (cur_q.stage == TOP_C3)) begin
                    tmr_val = BASE_HOLD + TMR_W'(settle_cycles);
                end else begin
                    tmr_val = BASE_HOLD;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: PH_RUN, depth: DEPTH_C2, stage: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign depth = cur_q.depth;
    assign stage = cur_q.stage;

endmodule

// File: rtl/cpu_idle_seq.sv
module cpu_idle_seq
    import cpu_idle_pkg::*;
#(
    parameter int                NUM_IRQ   = 24,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] LVL2_ADDR = 8'h14,
    parameter logic [ADDR_W-1:0] LVL3_ADDR = 8'h15,
    parameter int                STEP_MIN  = 4,
    parameter int                SETTLE_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [NUM_IRQ-1:0]  irq_req,
    input  logic [NUM_IRQ-1:0]  irq_mask,
    input  logic                nmi_evt,
    input  logic                smi_evt,
    input  logic                init_evt,
    input  logic                kbc_reset_req,
    input  logic                bm_req,
    output logic                deep_idle_n,
    output logic                stop_clk_n,
    output logic                cpu_sleep_n,
    output logic                cpu_clk_stop_n
);

    localparam int TMR_W = SETTLE_W + $clog2(STEP_MIN + 1) + 1;

    logic               wake;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_expired;
    depth_e             depth;
    logic [STAGE_W-1:0] stage;
    logic [NUM_PINS-1:0] pin_on;

    cpu_idle_brk_qual #(
        .NUM_IRQ(NUM_IRQ)
    ) u_qual (
        .irq_req       (irq_req),
        .irq_mask      (irq_mask),
        .nmi_evt       (nmi_evt),
        .smi_evt       (smi_evt),
        .init_evt      (init_evt),
        .kbc_reset_req (kbc_reset_req),
        .bm_req        (bm_req),
        .in_c3         (depth == DEPTH_C3),
        .wake          (wake)
    );

    cpu_idle_step_timer #(
        .TMR_W(TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    cpu_idle_seq_ctrl #(
        .ADDR_W    (ADDR_W),
        .LVL2_ADDR (LVL2_ADDR),
        .LVL3_ADDR (LVL3_ADDR),
        .STEP_MIN  (STEP_MIN),
        .SETTLE_W  (SETTLE_W),
        .TMR_W     (TMR_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_en         (rd_en),
        .rd_addr       (rd_addr),
        .settle_cycles (settle_cycles),
        .wake          (wake),
        .tmr_expired   (tmr_expired),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .depth         (depth),
        .stage         (stage)
    );

    cpu_idle_pin_map u_pins (
        .depth  (depth),
        .stage  (stage),
        .pin_on (pin_on)
    );

    assign deep_idle_n    = ~pin_on[PIN_DEEP];
    assign stop_clk_n     = ~pin_on[PIN_STOPCLK];
    assign cpu_sleep_n    = ~pin_on[PIN_SLEEP];
    assign cpu_clk_stop_n = ~pin_on[PIN_CPUCLK];

endmodule

// File: rtl/cpu_idle_seq_chk.sv
module cpu_idle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic deep_idle_n,
    input logic stop_clk_n,
    input logic cpu_sleep_n,
    input logic cpu_clk_stop_n
);

    // R4
    clkstop_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_stop_n |-> !cpu_sleep_n);

    // R4
    clkstop_only_c3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_stop_n |-> !deep_idle_n);

    // R4
    sleep_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_sleep_n |-> !stop_clk_n);

    // R3
    sleep_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_sleep_n) |-> !$past(stop_clk_n));

    // R3
    clkstop_after_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk_stop_n) |-> !$past(cpu_sleep_n));

    // R8
    sleep_release_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_sleep_n) |-> $past(cpu_clk_stop_n));

    // R8
    status_release_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(deep_idle_n) |-> $past(stop_clk_n));

endmodule

bind cpu_idle_seq cpu_idle_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .deep_idle_n    (deep_idle_n),
    .stop_clk_n     (stop_clk_n),
    .cpu_sleep_n    (cpu_sleep_n),
    .cpu_clk_stop_n (cpu_clk_stop_n)
);

// File: tb/tb_cpu_idle_seq.sv
module tb_cpu_idle_seq;

    localparam int          NUM_IRQ = 24;
    localparam logic [7:0]  A_L2    = 8'h14;
    localparam logic [7:0]  A_L3    = 8'h15;
    localparam int          SM      = 4;
    localparam int          SETTLE  = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rd_en = 1'b0;
    logic [7:0]         rd_addr = '0;
    logic [7:0]         settle_cycles = 8'(SETTLE);
    logic [NUM_IRQ-1:0] irq_req = '0;
    logic [NUM_IRQ-1:0] irq_mask = '0;
    logic               nmi_evt = 1'b0;
    logic               smi_evt = 1'b0;
    logic               init_evt = 1'b0;
    logic               kbc_reset_req = 1'b0;
    logic               bm_req = 1'b0;
    logic               deep_idle_n;
    logic               stop_clk_n;
    logic               cpu_sleep_n;
    logic               cpu_clk_stop_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cpu_idle_seq dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_en          (rd_en),
        .rd_addr        (rd_addr),
        .settle_cycles  (settle_cycles),
        .irq_req        (irq_req),
        .irq_mask       (irq_mask),
        .nmi_evt        (nmi_evt),
        .smi_evt        (smi_evt),
        .init_evt       (init_evt),
        .kbc_reset_req  (kbc_reset_req),
        .bm_req         (bm_req),
        .deep_idle_n    (deep_idle_n),
        .stop_clk_n     (stop_clk_n),
        .cpu_sleep_n    (cpu_sleep_n),
        .cpu_clk_stop_n (cpu_clk_stop_n)
    );

    // pins as {deep_idle_n, stop_clk_n, cpu_sleep_n, cpu_clk_stop_n}
    function automatic logic [3:0] pins();
        return {deep_idle_n, stop_clk_n, cpu_sleep_n, cpu_clk_stop_n};
    endfunction

    task automatic chk(input logic [3:0] exp, input string req);
        checks++;
        if (pins() !== exp) begin
            errors++;
            $display("FAIL %s pins actual %b expected %b at %0t", req, pins(), exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] a);
        rd_addr = a;
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en   = 1'b0;
    endtask

    task automatic t_reset();
        chk(4'b1111, "R1 reset");
        rst_n = 1'b1;
        wait_n(2);
        chk(4'b1111, "R1 idle after reset");
    endtask

    task automatic t_c3_cycle();
        do_read(A_L3);
        chk(4'b0111, "R3 status first");
        wait_n(SM - 1); chk(4'b0111, "R3 halt not early");
        wait_n(1);      chk(4'b0011, "R3 halt");
        wait_n(SM - 1); chk(4'b0011, "R3 sleep not early");
        wait_n(1);      chk(4'b0001, "R3 sleep");
        wait_n(SM - 1); chk(4'b0001, "R3 clkstop not early");
        wait_n(1);      chk(4'b0000, "R3 clkstop");
        wait_n(8);      chk(4'b0000, "R3 C3 residency");
        irq_req[23] = 1'b1;
        @(negedge clk);
        irq_req[23] = 1'b0;
        chk(4'b0001, "R8 R5 clock restart");
        wait_n(SM + SETTLE - 1); chk(4'b0001, "R8 settle hold");
        wait_n(1);      chk(4'b0011, "R8 sleep release");
        wait_n(SM - 1); chk(4'b0011, "R8 halt held");
        wait_n(1);      chk(4'b0111, "R8 halt release");
        wait_n(SM - 1); chk(4'b0111, "R8 status held");
        wait_n(1);      chk(4'b1111, "R8 back to C0");
    endtask

    task automatic t_c2_bm_mask();
        do_read(A_L2);
        chk(4'b1011, "R2 halt only");
        wait_n(SM + 2);
        bm_req = 1'b1;
        wait_n(4);      chk(4'b1011, "R7 bus master ignored in C2");
        irq_req[5] = 1'b1;
        irq_mask[5] = 1'b1;
        wait_n(3);      chk(4'b1011, "R5 masked line ignored");
        irq_mask[5] = 1'b0;
        @(negedge clk);
        chk(4'b1111, "R9 R5 unmasked wake from C2");
        irq_req[5] = 1'b0;
        bm_req = 1'b0;
        wait_n(2);      chk(4'b1111, "R9 stays in C0");
    endtask

    task automatic t_c3_bm();
        do_read(A_L3);
        wait_n(4 * SM + 4);
        chk(4'b0000, "R7 C3 resident");
        bm_req = 1'b1;
        @(negedge clk);
        bm_req = 1'b0;
        chk(4'b0001, "R7 bus master wakes C3");
        wait_n(3 * SM + SETTLE);
        chk(4'b1111, "R7 back to C0");
    endtask

    task automatic t_sys_events();
        do_read(A_L3);
        wait_n(4 * SM + 4);
        kbc_reset_req = 1'b1;
        @(negedge clk);
        kbc_reset_req = 1'b0;
        chk(4'b0001, "R6 keyboard reset wakes C3");
        wait_n(3 * SM + SETTLE);
        do_read(A_L2);
        wait_n(SM + 2);
        init_evt = 1'b1;
        @(negedge clk);
        init_evt = 1'b0;
        chk(4'b1111, "R6 INIT wakes C2");
        do_read(A_L2);
        wait_n(SM + 2);
        nmi_evt = 1'b1;
        @(negedge clk);
        nmi_evt = 1'b0;
        chk(4'b1111, "R6 NMI wakes C2");
    endtask

    task automatic t_abort();
        do_read(A_L3);
        wait_n(4);      chk(4'b0011, "R10 second step");
        wait_n(1);
        smi_evt = 1'b1;
        wait_n(2);      chk(4'b0011, "R10 wake waits for step end");
        wait_n(1);      chk(4'b0111, "R10 halt released at step end");
        smi_evt = 1'b0;
        wait_n(SM - 1); chk(4'b0111, "R10 status held one step");
        wait_n(1);      chk(4'b1111, "R10 back to C0");
    endtask

    task automatic t_ignored_reads();
        do_read(8'h20);
        wait_n(SM);     chk(4'b1111, "R11 other address ignored");
        do_read(A_L2);
        wait_n(SM + 2);
        do_read(A_L3);
        wait_n(2 * SM); chk(4'b1011, "R11 level read in C2 ignored");
        smi_evt = 1'b1;
        @(negedge clk);
        smi_evt = 1'b0;
        chk(4'b1111, "R6 SMI wakes C2");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        wait_n(3);
        t_reset();
        t_c3_cycle();
        t_c2_bm_mask();
        t_c3_bm();
        t_sys_events();
        t_abort();
        t_ignored_reads();
        wait_n(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule